// File: doc/BRIEF.md
# Dual-Protocol Serial Configuration Write Port

This block is the configuration entry point of a mixed-signal device. A host writes settings into it over one set of shared pins, using either a 3-wire select/clock/data bus or a 2-wire addressed bus. A static mode pin chooses the protocol. Each write carries a 7-bit register address and a 9-bit value. The block decodes the write and updates a small register file. That file holds the power enables, the input routing, the input gain and the automatic level control word, and each register has a defined reset value.

All three bus lines are sampled on a fast system clock. Each line passes through a two-flop synchronizer and then a run-length filter, so narrow spikes never reach the protocol logic. In 2-wire mode the port is a write-only slave with a fixed device address. It pulls the data line low to acknowledge the bytes it accepts. It stays silent for frames that carry a different address or that request a read.

Top module: `cfg_serial_port`

## Requirements
- R1: `mode_3w` high selects the 3-wire protocol and low selects the 2-wire protocol. While `mode_3w` is high, `sdin_pull` stays low.
- R2: In 3-wire mode, data bits are taken on rising `sclk_in` edges while `csb_in` is low, MSB first. Of the 16 bits, bits 15..9 are the register address and bits 8..0 are the data. The word is committed on the rising edge of `csb_in`, which raises `wr_stb` for exactly one cycle with `wr_addr`/`wr_data`.
- R3: A 3-wire frame with other than exactly 16 clock rises while `csb_in` is low produces no strobe and changes no register.
- R4: A 2-wire frame consists of a start, the address byte 0011010 followed by a 0 (write) bit, a byte {addr[6:0], data[8]}, a byte data[7:0], and a stop. All bytes are MSB first and sampled on rising clock. The strobe fires once the eighth bit of the last byte has been taken.
- R5: In 2-wire mode the port pulls the data line low (`sdin_pull`=1) through the ninth clock after the address byte and after each of the two data bytes. It changes `sdin_pull` only while the filtered clock is low.
- R6: A 2-wire frame with any other device address, or with the read bit set, is not acknowledged, raises no strobe and changes no register.
- R7: A pulse on any bus line shorter than FILT_LEN system clocks (3 clocks by default, so a 5 ns spike at 200 MHz) has no effect on decoding.
- R8: The register file holds 9-bit registers at addresses 2 (power), 32 (level control), 44 (input routing) and 45 (input gain). A written value appears on the matching output in the cycle after `wr_stb`.
- R9: After reset the registers read: address 2 = 0x000, 32 = 0x000, 44 = 0x003, 45 = 0x010.
- R10: A write to any other address still pulses `wr_stb` but leaves every register unchanged.
- R11: A 2-wire frame cut short by a stop or a repeated start before the last data bit writes nothing. A following complete frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_3w | input | 1 | Protocol select, 1 = 3-wire, 0 = 2-wire |
| csb_in | input | 1 | 3-wire chip select, active low |
| sclk_in | input | 1 | Serial clock (both protocols) |
| sdin_in | input | 1 | Serial data as seen on the bus |
| sdin_pull | output | 1 | Drives the data line low when 1 (open-drain acknowledge) |
| wr_stb | output | 1 | One-cycle pulse per decoded write |
| wr_addr | output | 7 | Register address of the decoded write |
| wr_data | output | 9 | Data of the decoded write |
| reg_pwr | output | 9 | Power register (address 2) |
| reg_alc | output | 9 | Level control register (address 32) |
| reg_inctl | output | 9 | Input routing register (address 44) |
| reg_gain | output | 9 | Input gain register (address 45) |

## Verification
The bench injects 5 ns spikes on the 3-wire clock, on the chip select and on the 2-wire data line while the clock is high. A missing or too short filter would show up as an extra shifted bit, an early commit or a false start or stop, and the write would then be lost or garbled. Frames with 15 and 17 clocks catch a decoder that commits on any select rise. Wrong device addresses, the read bit and a frame cut off after the first data byte catch a slave that acknowledges or writes too eagerly. Random writes to both implemented and unimplemented addresses would expose an address decode that aliases into the wrong register.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int NREG    = 4;
  localparam logic [ADDR_W-1:0] DEV_ADDR = 7'b0011010;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_word_t;

  typedef enum logic [2:0] {
    TW_IDLE, TW_ADDR, TW_AACK, TW_B1, TW_B1ACK, TW_B2, TW_B2ACK, TW_SKIP
  } tw_state_t;

  function automatic wr_word_t split_frame(input logic [FRAME_W-1:0] f);
    wr_word_t w;
    w.addr = f[FRAME_W-1:DATA_W];
    w.data = f[DATA_W-1:0];
    return w;
  endfunction

  function automatic logic dev_match(input logic [7:0] b);
    return (b[7:1] == DEV_ADDR) && !b[0];
  endfunction

  function automatic logic [ADDR_W-1:0] reg_addr(input int i);
    case (i)
      0: return 7'd2;
      1: return 7'd32;
      2: return 7'd44;
      default: return 7'd45;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_dflt(input int i);
    case (i)
      2: return 9'h003;
      3: return 9'h010;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic is_impl(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NREG; i++) if (a == reg_addr(i)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/cfgp_deglitch.sv
module cfgp_deglitch #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sync,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic          meta;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      sync <= RST_VAL;
      dout <= RST_VAL;
      run  <= '0;
    end else begin
      meta <= din;
      sync <= meta;
      if (sync == dout) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        dout <= sync;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgp_rx3w.sv
module cfgp_rx3w
  import cfgp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     csb_f,
  input  logic     sclk_f,
  input  logic     sdin_f,
  output logic     cmt,
  output wr_word_t word
);
  logic               csb_q, sclk_q;
  logic [FRAME_W-1:0] shreg;
  logic [4:0]         nbits;
  logic               csb_rise, csb_fall, clk_rise, frame_ok;

  assign csb_rise = csb_f && !csb_q;
  assign csb_fall = !csb_f && csb_q;
  assign clk_rise = sclk_f && !sclk_q && !csb_f;
  assign frame_ok = (nbits == 5'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csb_q  <= 1'b1;
      sclk_q <= 1'b1;
      shreg  <= '0;
      nbits  <= '0;
      cmt    <= 1'b0;
      word   <= '0;
    end else begin
      csb_q  <= csb_f;
      sclk_q <= sclk_f;
      cmt    <= 1'b0;
      if (!en) begin
        nbits <= '0;
      end else begin
        if (csb_fall) nbits <= '0;
        if (clk_rise) begin
          shreg <= {shreg[FRAME_W-2:0], sdin_f};
          if (nbits != 5'h1f) nbits <= nbits + 1'b1;
        end
        if (csb_rise && frame_ok) begin
          cmt  <= 1'b1;
          word <= split_frame(shreg);
        end
      end
    end
  end
endmodule

// File: rtl/cfgp_rx2w.sv
module cfgp_rx2w
  import cfgp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     scl_f,
  input  logic     sda_f,
  output logic     pull,
  output logic     cmt,
  output wr_word_t word
);
  tw_state_t  st;
  logic       scl_q, sda_q;
  logic [3:0] bitc;
  logic [7:0] sh, hi_byte;
  logic       start_ev, stop_ev, scl_rise, scl_fall, in_byte, in_ack;

  assign start_ev = scl_f && scl_q && !sda_f && sda_q;
  assign stop_ev  = scl_f && scl_q && sda_f && !sda_q;
  assign scl_rise = scl_f && !scl_q;
  assign scl_fall = !scl_f && scl_q;
  assign in_byte  = (st == TW_ADDR) || (st == TW_B1) || (st == TW_B2);
  assign in_ack   = (st == TW_AACK) || (st == TW_B1ACK) || (st == TW_B2ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TW_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bitc    <= '0;
      sh      <= '0;
      hi_byte <= '0;
      pull    <= 1'b0;
      cmt     <= 1'b0;
      word    <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      cmt   <= 1'b0;
      if (!en) begin
        st   <= TW_IDLE;
        pull <= 1'b0;
      end else if (start_ev) begin
        st   <= TW_ADDR;
        bitc <= '0;
        pull <= 1'b0;
      end else if (stop_ev) begin
        st   <= TW_IDLE;
        pull <= 1'b0;
      end else if (scl_rise && in_byte && bitc < 4'd8) begin
        sh   <= {sh[6:0], sda_f};
        bitc <= bitc + 1'b1;
        if (st == TW_B2 && bitc == 4'd7) begin
          cmt  <= 1'b1;
          word <= split_frame({hi_byte, sh[6:0], sda_f});
        end
      end else if (scl_fall && in_byte && bitc == 4'd8) begin
        case (st)
          TW_ADDR: begin
            if (dev_match(sh)) begin
              pull <= 1'b1;
              st   <= TW_AACK;
            end else begin
              st <= TW_SKIP;
            end
          end
          TW_B1: begin
            hi_byte <= sh;
            pull    <= 1'b1;
            st      <= TW_B1ACK;
          end
          default: begin
            pull <= 1'b1;
            st   <= TW_B2ACK;
          end
        endcase
      end else if (scl_fall && in_ack) begin
        pull <= 1'b0;
        bitc <= '0;
        case (st)
          TW_AACK:  st <= TW_B1;
          TW_B1ACK: st <= TW_B2;
          default:  st <= TW_SKIP;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  wr_word_t          word,
  output logic [DATA_W-1:0] q [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = stb && (word.addr == reg_addr(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= reg_dflt(i);
      else if (hit) q[i] <= word.data;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_3w,
  input  logic              csb_in,
  input  logic              sclk_in,
  input  logic              sdin_in,
  output logic              sdin_pull,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] reg_pwr,
  output logic [DATA_W-1:0] reg_alc,
  output logic [DATA_W-1:0] reg_inctl,
  output logic [DATA_W-1:0] reg_gain
);
  localparam int NLINE = 3;
  logic [NLINE-1:0] line_raw, line_s, line_f;
  logic             csb_f, sclk_f, sdin_f;
  logic             cmt3, cmt2, pull2;
  wr_word_t         word3, word2, word_sel;
  logic [DATA_W-1:0] regq [NREG];

  assign line_raw = {csb_in, sclk_in, sdin_in};

  for (genvar i = 0; i < NLINE; i++) begin : g_filt
    cfgp_deglitch #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_flt (
      .clk(clk), .rst_n(rst_n), .din(line_raw[i]),
      .sync(line_s[i]), .dout(line_f[i])
    );
  end

  assign csb_f  = line_f[2];
  assign sclk_f = line_f[1];
  assign sdin_f = line_f[0];

  cfgp_rx3w u_rx3 (
    .clk(clk), .rst_n(rst_n), .en(mode_3w),
    .csb_f(csb_f), .sclk_f(sclk_f), .sdin_f(sdin_f),
    .cmt(cmt3), .word(word3)
  );

  cfgp_rx2w u_rx2 (
    .clk(clk), .rst_n(rst_n), .en(!mode_3w),
    .scl_f(sclk_f), .sda_f(sdin_f),
    .pull(pull2), .cmt(cmt2), .word(word2)
  );

  assign wr_stb    = mode_3w ? cmt3 : cmt2;
  assign word_sel  = mode_3w ? word3 : word2;
  assign wr_addr   = word_sel.addr;
  assign wr_data   = word_sel.data;
  assign sdin_pull = pull2 && !mode_3w;

  cfgp_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .stb(wr_stb), .word(word_sel), .q(regq)
  );

  assign reg_pwr   = regq[0];
  assign reg_alc   = regq[1];
  assign reg_inctl = regq[2];
  assign reg_gain  = regq[3];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
  import cfgp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_3w,
  input logic [2:0]        line_s,
  input logic [2:0]        line_f,
  input logic              sclk_f,
  input logic              sdin_pull,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] reg_pwr,
  input logic [DATA_W-1:0] reg_alc,
  input logic [DATA_W-1:0] reg_inctl,
  input logic [DATA_W-1:0] reg_gain
);
  AST_NO_PULL_3W: assert property (@(posedge clk) disable iff (!rst_n)
    mode_3w |-> !sdin_pull); // R1

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R2

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdin_pull) |-> !sclk_f); // R5

  for (genvar i = 0; i < 3; i++) begin : g_flt
    AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_f[i]) |-> ($past(line_s[i]) == line_f[i]) &&
                              ($past(line_s[i], 2) == line_f[i])); // R7
  end

  AST_GAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_gain) |-> $past(wr_stb) && ($past(wr_addr) == 7'd45)); // R8

  AST_INCTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_inctl) |-> $past(wr_stb) && ($past(wr_addr) == 7'd44)); // R8

  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !is_impl(wr_addr)) |=> $stable(reg_pwr) && $stable(reg_alc) &&
                                      $stable(reg_inctl) && $stable(reg_gain)); // R10
endmodule

bind cfg_serial_port cfgp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .line_s(line_s), .line_f(line_f),
  .sclk_f(sclk_f), .sdin_pull(sdin_pull), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .reg_pwr(reg_pwr), .reg_alc(reg_alc), .reg_inctl(reg_inctl), .reg_gain(reg_gain)
);

// File: tb/cfg_serial_port_test.sv
`timescale 1ns/1ps
module cfg_serial_port_test;
  logic clk = 0, rst_n = 0, mode_3w = 1, csb = 1, sclk = 0, sdin_m = 1;
  logic sdin_pull, wr_stb;
  logic [6:0] wr_addr;
  logic [8:0] wr_data, reg_pwr, reg_alc, reg_inctl, reg_gain;
  wire sdin_bus = sdin_m & ~sdin_pull;

  int total = 0, bad = 0, stb_n = 0;
  logic [6:0] last_a;
  logic [8:0] last_d;
  logic [8:0] m_pwr, m_alc, m_inctl, m_gain;
  bit done = 0;
  localparam int Q = 100;

  always #2.5 clk = ~clk;

  cfg_serial_port uut (
    .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .csb_in(csb), .sclk_in(sclk),
    .sdin_in(sdin_bus), .sdin_pull(sdin_pull), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .reg_pwr(reg_pwr), .reg_alc(reg_alc), .reg_inctl(reg_inctl),
    .reg_gain(reg_gain)
  );

  always @(negedge clk) if (rst_n && wr_stb) begin
    stb_n++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit impl(logic [6:0] a);
    return a == 7'd2 || a == 7'd32 || a == 7'd44 || a == 7'd45;
  endfunction

  task automatic model_write(logic [6:0] a, logic [8:0] d);
    case (a)
      7'd2:  m_pwr = d;
      7'd32: m_alc = d;
      7'd44: m_inctl = d;
      7'd45: m_gain = d;
      default: ;
    endcase
  endtask

  task automatic check_regs(string req);
    @(negedge clk);
    check({req, " pwr"}, 16'(reg_pwr), 16'(m_pwr));
    check({req, " alc"}, 16'(reg_alc), 16'(m_alc));
    check({req, " inctl"}, 16'(reg_inctl), 16'(m_inctl));
    check({req, " gain"}, 16'(reg_gain), 16'(m_gain));
  endtask

  task automatic do_reset(bit m3);
    rst_n = 0; mode_3w = m3; csb = 1; sclk = m3 ? 1'b0 : 1'b1; sdin_m = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    m_pwr = 9'h000; m_alc = 9'h000; m_inctl = 9'h003; m_gain = 9'h010;
    check_regs("R9 defaults");
  endtask

  // 3-wire frame; nclk clock rises, glitch inserts 5 ns spikes on sclk and csb
  task automatic tw3(logic [15:0] f, int nclk, bit glitch);
    csb = 0; #50;
    for (int i = nclk - 1; i >= 0; i--) begin
      sdin_m = (i < 16) ? f[i] : 1'b0;
      #50 sclk = 1; #50 sclk = 0;
      if (glitch) begin
        #20 sclk = 1; #5 sclk = 0;
        #10 csb = 1; #5 csb = 0;
      end
    end
    #50 csb = 1; #200;
  endtask

  task automatic i2_start;
    sdin_m = 1; sclk = 1; #Q; sdin_m = 0; #Q; sclk = 0; #Q;
  endtask

  task automatic i2_stop;
    sdin_m = 0; #Q; sclk = 1; #Q; sdin_m = 1; #(2*Q);
  endtask

  task automatic i2_byte(logic [7:0] b, bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdin_m = b[i]; #Q; sclk = 1; #Q;
      if (glitch) begin sdin_m = ~b[i]; #5; sdin_m = b[i]; end
      #Q; sclk = 0; #Q;
    end
    sdin_m = 1; #Q; sclk = 1; #Q;
    ack = (sdin_bus == 1'b0);
    #Q; sclk = 0; #Q;
  endtask

  task automatic i2_frame(logic [7:0] dev, logic [6:0] a, logic [8:0] d,
                          bit glitch, output bit [2:0] acks);
    bit k;
    acks = '0;
    i2_start;
    i2_byte(dev, glitch, k); acks[2] = k;
    i2_byte({a, d[8]}, glitch, k); acks[1] = k;
    i2_byte(d[7:0], glitch, k); acks[0] = k;
    i2_stop;
  endtask

  task automatic w3_expect(logic [6:0] a, logic [8:0] d, int nclk, bit glitch, string req);
    int s0 = stb_n;
    bit good = (nclk == 16);
    tw3({a, d}, nclk, glitch);
    check({req, " strobes"}, 16'(stb_n - s0), good ? 16'd1 : 16'd0);
    if (good) begin
      check({req, " addr"}, 16'(last_a), 16'(a));
      check({req, " data"}, 16'(last_d), 16'(d));
      model_write(a, d);
    end
    check_regs(req);
  endtask

  task automatic w2_expect(logic [7:0] dev, logic [6:0] a, logic [8:0] d, bit glitch, string req);
    int s0 = stb_n;
    bit [2:0] acks;
    bit good = (dev == 8'h34);
    i2_frame(dev, a, d, glitch, acks);
    check({req, " R5 acks"}, 16'(acks), good ? 16'h7 : 16'h0);
    check({req, " strobes"}, 16'(stb_n - s0), good ? 16'd1 : 16'd0);
    if (good) begin
      check({req, " addr"}, 16'(last_a), 16'(a));
      check({req, " data"}, 16'(last_d), 16'(d));
      model_write(a, d);
    end
    check_regs(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    bit k;
    bit [2:0] acks;
    logic [6:0] a;
    logic [8:0] d;
    void'($urandom(32'd4711));

    // 3-wire mode
    do_reset(1'b1);
    check("R1 no pull in 3w", 16'(sdin_pull), 16'd0);
    w3_expect(7'd45, 9'h1a5, 16, 1'b0, "R2 R8 gain");
    w3_expect(7'd44, 9'h0f0, 16, 1'b0, "R2 R8 inctl");
    w3_expect(7'd2, 9'h155, 15, 1'b0, "R3 short");
    w3_expect(7'd2, 9'h155, 17, 1'b0, "R3 long");
    w3_expect(7'd99, 9'h1ff, 16, 1'b0, "R10 unimpl");
    w3_expect(7'd32, 9'h0c3, 16, 1'b1, "R7 glitch 3w");
    for (int i = 0; i < 12; i++) begin
      case ($urandom % 5)
        0: a = 7'd2; 1: a = 7'd32; 2: a = 7'd44; 3: a = 7'd45;
        default: a = 7'($urandom);
      endcase
      d = 9'($urandom);
      w3_expect(a, d, 16, 1'($urandom % 2), impl(a) ? "R2 R8 rand" : "R10 rand");
    end
    check("R1 pull quiet 3w", 16'(sdin_pull), 16'd0);

    // 2-wire mode
    do_reset(1'b0);
    w2_expect(8'h34, 7'd45, 9'h13c, 1'b0, "R4 gain");
    w2_expect(8'h36, 7'd44, 9'h0aa, 1'b0, "R6 other dev");
    w2_expect(8'h35, 7'd44, 9'h0aa, 1'b0, "R6 read bit");
    w2_expect(8'h34, 7'd120, 9'h1ff, 1'b0, "R10 unimpl 2w");
    w2_expect(8'h34, 7'd2, 9'h1e1, 1'b1, "R7 glitch 2w");
    // truncated frame: stop after first data byte
    s0 = stb_n;
    i2_start;
    i2_byte(8'h34, 1'b0, k);
    i2_byte({7'd32, 1'b1}, 1'b0, k);
    i2_stop;
    check("R11 truncated strobes", 16'(stb_n - s0), 16'd0);
    check_regs("R11 truncated");
    // repeated start mid-frame then a full frame
    s0 = stb_n;
    i2_start;
    i2_byte(8'h34, 1'b0, k);
    i2_byte({7'd44, 1'b0}, 1'b0, k);
    i2_start;
    i2_byte(8'h34, 1'b0, k); acks[2] = k;
    i2_byte({7'd44, 1'b1}, 1'b0, k); acks[1] = k;
    i2_byte(8'h23, 1'b0, k); acks[0] = k;
    i2_stop;
    check("R11 restart acks", 16'(acks), 16'h7);
    check("R11 restart strobes", 16'(stb_n - s0), 16'd1);
    model_write(7'd44, 9'h123);
    check_regs("R11 restart");
    for (int i = 0; i < 10; i++) begin
      case ($urandom % 5)
        0: a = 7'd2; 1: a = 7'd32; 2: a = 7'd44; 3: a = 7'd45;
        default: a = 7'($urandom);
      endcase
      d = 9'($urandom);
      w2_expect(($urandom % 4 == 0) ? 8'h36 : 8'h34, a, d, 1'b0, "R4 R6 rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule